// File: doc/BRIEF.md
# Dual-Enable Asynchronous Static RAM Model

This block is a synthesizable stand-in for a byte-wide asynchronous static RAM. It can sit inside a chip or an emulation fabric where the real memory's pins are driven by logic that knows nothing of clocks. The address, two chip selects of opposite polarity, an active-low output enable, an active-low write enable and the write data are all sampled by a free-running oversampling clock. The bidirectional data pin is split into a read-data output, a drive-enable output and a write-data input.

Every sampled cycle, the control pins are decoded into one of four modes: standby, selected-but-not-driving, read and write. Write-enable low takes precedence over the output enable. A write opens only while both selects are active and write enable is low. If any one of the three drops, the write ends. The value stored is the last one sampled before that closing edge, so data that changes at or after the closing edge has no effect. The depth is a parameter. Nineteen address bits give the full 524,288-word part; the default is smaller so that elaboration stays light. A standby flag reports whenever the part is deselected.

Top module: `async_sram_model`

## Requirements
- R1: When `cs_lo_n` is 1 or `cs_hi` is 0 (as sampled), `standby_o` is 1 and `rdata_oe` is 0; otherwise `standby_o` is 0.
- R2: `rdata_o` is all zeros whenever `rdata_oe` is 0. When the part is selected with `oe_n`=1 and `we_n`=1, `rdata_oe` is 0 and nothing is written.
- R3: When the part is selected with `oe_n`=0 and `we_n`=1, `rdata_oe` is 1 and `rdata_o` holds the word stored at the sampled address.
- R4: When the part is selected with `we_n`=0, `rdata_oe` is 0 whatever `oe_n` is, and a write takes place.
- R5: A write ends when `we_n` rises, when `cs_lo_n` rises or when `cs_hi` falls. Each of the three commits the word.
- R6: Holding `we_n` low while the part is deselected leaves the memory unchanged.
- R7: Pin values present at clock edge n decide the outputs that appear after edge n+2. The pins pass through two synchronizing stages and one output register.
- R8: While `rst_n` is 0, `rdata_oe` is 0, `rdata_o` is 0 and `standby_o` is 1.
- R9: The word stored is the last data sampled while the write was open. Data sampled on the closing edge or later is ignored.
- R10: The write goes to the address sampled in the last open cycle. Each of the 2^ADDR_W addresses holds its own word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| addr_i | input | ADDR_W | Word address |
| cs_lo_n | input | 1 | Chip select, active low |
| cs_hi | input | 1 | Chip select, active high |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wdata_i | input | DATA_W | Data into the part (receive side of the data pin) |
| rdata_o | output | DATA_W | Data out of the part (drive side of the data pin) |
| rdata_oe | output | 1 | Drive enable of the data pin; 0 means high impedance |
| standby_o | output | 1 | Deselected flag |

## Verification
The bench builds the block with ADDR_W = 6 and DATA_W = 8. At that depth, a sweep writes and reads back every one of the 64 words, so address aliasing shows up within a few thousand cycles. The data width keeps complement patterns byte-wide, which exercises each data bit in both directions. The synchronizer depth stays at its default of two, so the bench's three-edge latency model matches R7.

// File: rtl/sram_model_pkg.sv
package sram_model_pkg;

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_NODRIVE = 2'd1,
    MODE_READ    = 2'd2,
    MODE_WRITE   = 2'd3
  } sram_mode_e;

  typedef struct packed {
    logic cs_lo_n;
    logic cs_hi;
    logic oe_n;
    logic we_n;
  } sram_ctrl_t;

  localparam int CTRL_W = $bits(sram_ctrl_t);

  localparam sram_ctrl_t CTRL_IDLE = '{cs_lo_n: 1'b1, cs_hi: 1'b0, oe_n: 1'b1, we_n: 1'b1};

endpackage

// File: rtl/sram_pin_sync.sv
module sram_pin_sync #(
  parameter int             W      = 4,
  parameter int             STAGES = 2,
  parameter logic [W-1:0]   RST    = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d_i;
    for (int i = 1; i < STAGES; i++) begin
      stage_d[i] = stage_q[i-1];
    end
  end

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[g] <= RST;
        end else begin
          stage_q[g] <= stage_d[g];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/sram_mode_dec.sv
module sram_mode_dec
  import sram_model_pkg::*;
(
  input  sram_ctrl_t ctrl_i,
  output sram_mode_e mode_o
);

  logic selected;

  always_comb begin
    selected = !ctrl_i.cs_lo_n && ctrl_i.cs_hi;
    if (!selected) begin
      mode_o = MODE_STANDBY;
    end else if (!ctrl_i.we_n) begin
      mode_o = MODE_WRITE;
    end else if (!ctrl_i.oe_n) begin
      mode_o = MODE_READ;
    end else begin
      mode_o = MODE_NODRIVE;
    end
  end

endmodule

// File: rtl/sram_wr_ctl.sv
module sram_wr_ctl
  import sram_model_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sram_mode_e    mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          commit_o,
  output logic [AW-1:0] commit_addr_o,
  output logic [DW-1:0] commit_data_o
);

  logic          win_now;
  logic          win_q;
  logic          win_d;
  logic [AW-1:0] hold_addr_q, hold_addr_d;
  logic [DW-1:0] hold_data_q, hold_data_d;
  logic          hold_en;

  always_comb begin
    win_now     = (mode_i == MODE_WRITE);
    win_d       = win_now;
    hold_en     = win_now;
    hold_addr_d = hold_en ? addr_i : hold_addr_q;
    hold_data_d = hold_en ? data_i : hold_data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q       <= 1'b0;
      hold_addr_q <= '0;
      hold_data_q <= '0;
    end else begin
      win_q       <= win_d;
      hold_addr_q <= hold_addr_d;
      hold_data_q <= hold_data_d;
    end
  end

  assign commit_o      = win_q && !win_now;
  assign commit_addr_o = hold_addr_q;
  assign commit_data_o = hold_data_q;

endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      mem[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem[rd_addr_i];

endmodule

// File: rtl/async_sram_model.sv
module async_sram_model
  import sram_model_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cs_lo_n,
  input  logic              cs_hi,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe,
  output logic              standby_o
);

  localparam int BUS_W = ADDR_W + DATA_W;

  sram_ctrl_t        ctrl_raw, ctrl_s;
  logic [BUS_W-1:0]  bus_raw, bus_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;
  sram_mode_e        mode;

  logic              commit;
  logic [ADDR_W-1:0] commit_addr;
  logic [DATA_W-1:0] commit_data;
  logic [DATA_W-1:0] arr_rd;

  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic              oe_d, oe_q;
  logic              sb_d, sb_q;

  always_comb begin
    ctrl_raw = '{cs_lo_n: cs_lo_n, cs_hi: cs_hi, oe_n: oe_n, we_n: we_n};
    bus_raw  = {addr_i, wdata_i};
  end

  sram_pin_sync #(
    .W      (CTRL_W),
    .STAGES (SYNC_STAGES),
    .RST    (CTRL_IDLE)
  ) u_ctrl_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (ctrl_raw),
    .q_o   (ctrl_s)
  );

  sram_pin_sync #(
    .W      (BUS_W),
    .STAGES (SYNC_STAGES),
    .RST    ('0)
  ) u_bus_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (bus_raw),
    .q_o   (bus_s)
  );

  assign addr_s = bus_s[BUS_W-1:DATA_W];
  assign data_s = bus_s[DATA_W-1:0];

  sram_mode_dec u_dec (
    .ctrl_i (ctrl_s),
    .mode_o (mode)
  );

  sram_wr_ctl #(
    .AW (ADDR_W),
    .DW (DATA_W)
  ) u_wr (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (mode),
    .addr_i        (addr_s),
    .data_i        (data_s),
    .commit_o      (commit),
    .commit_addr_o (commit_addr),
    .commit_data_o (commit_data)
  );

  sram_array #(
    .AW (ADDR_W),
    .DW (DATA_W)
  ) u_arr (
    .clk       (clk),
    .wr_en_i   (commit),
    .wr_addr_i (commit_addr),
    .wr_data_i (commit_data),
    .rd_addr_i (addr_s),
    .rd_data_o (arr_rd)
  );

  always_comb begin
    oe_d    = (mode == MODE_READ);
    sb_d    = (mode == MODE_STANDBY);
    rdata_d = oe_d ? arr_rd : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      oe_q    <= 1'b0;
      sb_q    <= 1'b1;
    end else begin
      rdata_q <= rdata_d;
      oe_q    <= oe_d;
      sb_q    <= sb_d;
    end
  end

  assign rdata_o   = rdata_q;
  assign rdata_oe  = oe_q;
  assign standby_o = sb_q;

endmodule

// File: rtl/async_sram_model_chk.sv
module async_sram_model_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_lo_n,
  input logic          cs_hi,
  input logic          oe_n,
  input logic          we_n,
  input logic [DW-1:0] rdata_o,
  input logic          rdata_oe,
  input logic          standby_o
);

  logic [1:0] age_q, age_d;

  always_comb begin
    age_d = (age_q == 2'd3) ? age_q : age_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else        age_q <= age_d;
  end

  // R1: a deselected part never drives
  assert_standby_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    standby_o |-> !rdata_oe);

  // R1: deselected pins three edges back give the standby flag
  assert_standby_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((age_q == 2'd3) && ($past(cs_lo_n, 3) || !$past(cs_hi, 3))) |-> standby_o);

  // R2: an undriven port carries zeros
  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe |-> (rdata_o == '0));

  // R3: read mode pins lead to a driven port
  assert_read_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((age_q == 2'd3) && !$past(cs_lo_n, 3) && $past(cs_hi, 3) &&
     !$past(oe_n, 3) && $past(we_n, 3)) |-> rdata_oe);

  // R4: write enable low beats output enable
  assert_write_no_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((age_q == 2'd3) && !$past(we_n, 3)) |-> !rdata_oe);

endmodule

bind async_sram_model async_sram_model_chk #(
  .DW (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_lo_n   (cs_lo_n),
  .cs_hi     (cs_hi),
  .oe_n      (oe_n),
  .we_n      (we_n),
  .rdata_o   (rdata_o),
  .rdata_oe  (rdata_oe),
  .standby_o (standby_o)
);

// File: tb/sim_async_sram_model.sv
module sim_async_sram_model;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int WATCHDOG = 50000;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] addr_i;
  logic          cs_lo_n, cs_hi, oe_n, we_n;
  logic [DW-1:0] wdata_i;
  logic [DW-1:0] rdata_o;
  logic          rdata_oe, standby_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  async_sram_model #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .cs_lo_n(cs_lo_n), .cs_hi(cs_hi),
    .oe_n(oe_n), .we_n(we_n), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .rdata_oe(rdata_oe), .standby_o(standby_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model ----------------
  typedef struct {
    bit lo_n; bit hi; bit oe; bit we; int a; int d;
  } smp_t;

  smp_t        hq[$];
  int          mm[int];
  bit          e_oe, e_sb, e_known;
  int          e_dat;

  function automatic smp_t idle_smp();
    smp_t s;
    s.lo_n = 1; s.hi = 0; s.oe = 1; s.we = 1; s.a = 0; s.d = 0;
    return s;
  endfunction

  function automatic bit sel_f(smp_t s);
    return !s.lo_n && s.hi;
  endfunction

  function automatic bit win_f(smp_t s);
    return sel_f(s) && !s.we;
  endfunction

  initial begin
    e_oe = 0; e_sb = 1; e_dat = 0; e_known = 1;
  end

  always @(posedge clk) begin
    smp_t cur, p, pp;
    if (!rst_n) begin
      hq.delete();
      for (int i = 0; i < 4; i++) hq.push_front(idle_smp());
      e_oe = 0; e_sb = 1; e_dat = 0; e_known = 1;
    end else begin
      cur.lo_n = cs_lo_n; cur.hi = cs_hi; cur.oe = oe_n; cur.we = we_n;
      cur.a = int'(addr_i); cur.d = int'(wdata_i);
      hq.push_front(cur);
      p  = hq[2];
      pp = hq[3];
      e_sb    = !sel_f(p);
      e_oe    = sel_f(p) && p.we && !p.oe;
      e_known = !e_oe || mm.exists(p.a);
      e_dat   = (e_oe && e_known) ? mm[p.a] : 0;
      if (win_f(pp) && !win_f(p)) mm[pp.a] = pp.d;
      void'(hq.pop_back());
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R1, R2, R3)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(standby_o == e_sb, "R1 standby flag", int'(standby_o), int'(e_sb));
      chk(rdata_oe == e_oe, "R3 drive enable", int'(rdata_oe), int'(e_oe));
      if (e_known)
        chk(int'(rdata_o) == e_dat, "R2/R3 data port", int'(rdata_o), e_dat);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic go_idle();
    @(negedge clk);
    cs_lo_n = 1; cs_hi = 0; oe_n = 1; we_n = 1;
  endtask

  task automatic wr(input int a, input int d, input int how);
    @(negedge clk);
    addr_i = AW'(a); wdata_i = DW'(d);
    cs_lo_n = 0; cs_hi = 1; oe_n = 1; we_n = 0;
    repeat (3) @(negedge clk);
    wdata_i = DW'(~d);
    addr_i  = AW'(a + 1);
    case (how)
      0: we_n = 1;
      1: cs_lo_n = 1;
      default: cs_hi = 0;
    endcase
    @(negedge clk);
    cs_lo_n = 1; cs_hi = 0; we_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd_chk(input int a, input int exp, input string tag);
    @(negedge clk);
    addr_i = AW'(a); cs_lo_n = 0; cs_hi = 1; oe_n = 0; we_n = 1;
    repeat (3) @(negedge clk);
    chk(rdata_oe == 1'b1, tag, int'(rdata_oe), 1);
    chk(int'(rdata_o) == exp, tag, int'(rdata_o), exp);
    cs_lo_n = 1; cs_hi = 0; oe_n = 1;
  endtask

  initial begin
    rst_n = 0; addr_i = '0; wdata_i = '0;
    cs_lo_n = 0; cs_hi = 1; oe_n = 0; we_n = 1;
    repeat (4) @(negedge clk);
    // R8: reset state, even with read-mode pins
    chk(rdata_oe == 0, "R8 reset drive enable", int'(rdata_oe), 0);
    chk(rdata_o == 0, "R8 reset data", int'(rdata_o), 0);
    chk(standby_o == 1, "R8 reset standby", int'(standby_o), 1);
    cs_lo_n = 1; cs_hi = 0; oe_n = 1;
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R5: each of the three signals can close a write
    wr(5, 8'h3C, 0);
    wr(6, 8'hA5, 1);
    wr(7, 8'h5A, 2);
    rd_chk(5, 8'h3C, "R5 closed by write enable");
    rd_chk(6, 8'hA5, "R5 closed by low-active select");
    rd_chk(7, 8'h5A, "R5 closed by high-active select");
    go_idle();

    // R7: latency of three edges
    @(negedge clk);
    addr_i = 6'd5; cs_lo_n = 0; cs_hi = 1; oe_n = 0; we_n = 1;
    repeat (2) @(negedge clk);
    chk(rdata_oe == 0, "R7 not yet driven after two edges", int'(rdata_oe), 0);
    @(negedge clk);
    chk(rdata_oe == 1, "R7 driven after three edges", int'(rdata_oe), 1);
    go_idle();

    // R9: data changing in the window; last sample wins
    @(negedge clk);
    addr_i = 6'd9; cs_lo_n = 0; cs_hi = 1; oe_n = 1; we_n = 0; wdata_i = 8'h11;
    @(negedge clk); wdata_i = 8'h22;
    @(negedge clk); wdata_i = 8'h33;
    @(negedge clk); wdata_i = 8'h44; we_n = 1;
    @(negedge clk); wdata_i = 8'h55;
    repeat (2) @(negedge clk);
    rd_chk(9, 8'h33, "R9 last data before close");

    // R10: address moving in the window; last address gets the word
    @(negedge clk);
    addr_i = 6'd20; wdata_i = 8'h77; cs_lo_n = 0; cs_hi = 1; we_n = 0;
    @(negedge clk); addr_i = 6'd21;
    @(negedge clk); we_n = 1; addr_i = 6'd22;
    go_idle();
    wr(20, 8'h01, 0);
    rd_chk(21, 8'h77, "R10 last address in window");
    rd_chk(20, 8'h01, "R10 neighbour untouched");

    // R6: write enable low while deselected stores nothing
    @(negedge clk);
    addr_i = 6'd5; wdata_i = 8'hFF; cs_lo_n = 1; cs_hi = 1; we_n = 0;
    repeat (3) @(negedge clk);
    cs_lo_n = 0; cs_hi = 0;
    repeat (3) @(negedge clk);
    chk(standby_o == 1, "R1 standby with high-active select low", int'(standby_o), 1);
    we_n = 1;
    go_idle();
    repeat (2) @(negedge clk);
    rd_chk(5, 8'h3C, "R6 deselected write ignored");

    // R2: selected, no output enable: no drive, no write
    @(negedge clk);
    addr_i = 6'd6; wdata_i = 8'h00; cs_lo_n = 0; cs_hi = 1; oe_n = 1; we_n = 1;
    repeat (3) @(negedge clk);
    chk(rdata_oe == 0, "R2 output disabled", int'(rdata_oe), 0);
    chk(standby_o == 0, "R2 selected not standby", int'(standby_o), 0);
    go_idle();
    rd_chk(6, 8'hA5, "R2 no write in output-disable");

    // R4: write enable overrides output enable
    @(negedge clk);
    addr_i = 6'd30; wdata_i = 8'hC3; cs_lo_n = 0; cs_hi = 1; oe_n = 0; we_n = 0;
    repeat (3) @(negedge clk);
    chk(rdata_oe == 0, "R4 no drive during write", int'(rdata_oe), 0);
    we_n = 1;
    @(negedge clk); oe_n = 1; cs_lo_n = 1; cs_hi = 0;
    repeat (2) @(negedge clk);
    rd_chk(30, 8'hC3, "R4 write with output enable low");

    // R10: full sweep of all words
    for (int a = 0; a < (1 << AW); a++) wr(a, (a * 37 + 11) & 8'hFF, a % 3);
    for (int a = 0; a < (1 << AW); a++) rd_chk(a, (a * 37 + 11) & 8'hFF, "R10 sweep readback");

    // R3: streaming reads, address changes every cycle (model compares each clock)
    @(negedge clk);
    cs_lo_n = 0; cs_hi = 1; oe_n = 0; we_n = 1;
    for (int a = 0; a < (1 << AW); a++) begin
      addr_i = AW'((a * 13) % (1 << AW));
      @(negedge clk);
    end
    go_idle();
    repeat (4) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule